// File: doc/BRIEF.md
# Pseudo-Static RAM Pin-Level Core

This block is a clocked, synthesizable model of a word-wide pseudo-static RAM that keeps the device's own pin-level control scheme. It has an active-low chip enable, an address bus, one write strobe and one output enable per byte lane, and a lower output enable that also serves as the refresh request. All pins are sampled on the rising edge of `clk`. The block finds the edges of chip enable and of the strobes by comparing each sample with the one before it.

The address is captured when chip enable goes active and is held for the rest of the access. A byte lane takes its write data when its strobe is released, or when chip enable is released while the strobe is still low. Each lane drives read data only when its output enable is low and its strobe is high. The bidirectional data bus is split into `din`, `dout` and one drive enable per lane.

A chip-enable cycle in which no lane reads or writes is a refresh of the row given by the low eight address bits. A falling refresh request while chip enable is idle is an auto refresh of the row held in an internal 8-bit row counter. Both kinds of refresh are reported on `ref_valid`/`ref_row`, which feed the row decoder. With `ADDR_W` = 15 the array is the full 32K x 16 organisation. The default is a smaller depth, and only the column part of the address changes with it.

Top module: `psram_core`

## Requirements
- R1: After reset `drv_lo`, `drv_hi` and `ref_valid` are 0, and the first auto refresh reports row 0.
- R2: The address is taken on the sample where `ce_n` goes from 1 to 0. Later changes of `addr` inside the same access change neither the written word nor the word read.
- R3: With `ce_n` low, a lane whose strobe (`wr_lo_n` for bits 7:0, `wr_hi_n` for bits 15:8) goes from 0 to 1 writes that lane's `din` byte, as sampled at that rise, into the latched word. The other lane is left unchanged.
- R4: When `ce_n` goes from 0 to 1 while a lane's strobe is still low, that lane's `din` byte, as sampled at the rise of `ce_n`, is written into the latched word.
- R5: `drv_lo` (`drv_hi`) is 1 in the cycle after a sample with `ce_n`=0, `oe_lo_rf_n`=0 (`oe_hi_n`=0) and `wr_lo_n`=1 (`wr_hi_n`=1). `dout` then carries that lane of the latched word, including a write committed at the same sample.
- R6: A lane whose strobe and output enable are both low is not driven.
- R7: While `ce_n` is 1 and `oe_lo_rf_n` stays 1, both lanes are undriven and `ref_valid` stays 0, whatever the other pins do.
- R8: A chip-enable access in which no sample has any output enable or strobe low ends, on the rise of `ce_n`, with a one-cycle `ref_valid` pulse whose `ref_row` is the latched `addr[7:0]`. Neither lane is driven during such an access.
- R9: With `ce_n` 1 in the current and the previous sample, a 1-to-0 transition of `oe_lo_rf_n` gives a one-cycle `ref_valid` pulse with `ref_row` equal to the counter, and the counter then increments, wrapping from 255 to 0. `addr`, the strobes and `oe_hi_n` have no effect, and the stored data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address; bits 7:0 are the row |
| wr_lo_n | input | 1 | Lower-lane write strobe, active low |
| wr_hi_n | input | 1 | Upper-lane write strobe, active low |
| oe_lo_rf_n | input | 1 | Lower-lane output enable and refresh request, active low |
| oe_hi_n | input | 1 | Upper-lane output enable, active low |
| din | input | 16 | Write data |
| dout | output | 16 | Read data |
| drv_lo | output | 1 | Drive enable for dout[7:0] |
| drv_hi | output | 1 | Drive enable for dout[15:8] |
| ref_valid | output | 1 | One-cycle pulse: a row is refreshed |
| ref_row | output | 8 | Row being refreshed |

## Verification
The bench moves the address pins after chip enable has gone active. A design that used the live address would then write to or read from the wrong word. It writes through both commit paths, strobe release and chip-enable release. A model that used only one of them would leave stale bytes, and a model with no per-lane masking would corrupt the other byte. It holds a strobe and an output enable low together: a wrong priority shows up as a lane driving during a write. It runs 260 auto refreshes with junk on the ignored pins. A counter that did not wrap, counted refresh-only accesses, or took the address would report the wrong rows, and a refresh that wrote to the array would show up when the data is read back.

// File: rtl/psram_pkg.sv
// Package: shared constants for the pseudo-static RAM core.
// Assumes two byte lanes; lane 0 is the lower byte, lane 1 the upper byte.
package psram_pkg;
    localparam int LANES   = 2;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;
endpackage

// File: rtl/psram_ctrl.sv
// psram_ctrl: samples the control pins, finds the edges of chip enable,
// the strobes and the refresh request, latches the address and decides
// per lane whether to commit a write or drive read data, and which refresh
// kind (if any) happens at this sample.
// Assumes all pins are synchronous to clk; one sample per clock.
module psram_ctrl #(
    parameter int ADDR_W = 11,
    parameter int ROW_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ce_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [psram_pkg::LANES-1:0]     wr_n,
    input  logic [psram_pkg::LANES-1:0]     oe_n,
    output logic [ADDR_W-1:0]               rd_addr,
    output logic [ADDR_W-1:0]               wr_addr,
    output logic [psram_pkg::LANES-1:0]     lane_we,
    output logic [psram_pkg::LANES-1:0]     lane_drv,
    output logic                            ce_ref_go,
    output logic [ROW_W-1:0]                ce_row,
    output logic                            auto_go
);
    import psram_pkg::*;

    logic               ce_q;
    logic [LANES-1:0]   wr_q;
    logic               rf_q;
    logic [ADDR_W-1:0]  addr_lat;
    logic               touched;
    logic               ce_fall;
    logic               ce_rise;
    logic               busy_now;

    // Edge detection against the previous sample.
    always_comb begin
        ce_fall  = !ce_n && ce_q;
        ce_rise  = ce_n && !ce_q;
        busy_now = !(&{oe_n, wr_n});
    end

    // Address used for reading: the pins on the first sample, then the latch.
    always_comb begin
        rd_addr = ce_fall ? addr : addr_lat;
        wr_addr = addr_lat;
        ce_row  = addr_lat[ROW_W-1:0];
    end

    // Per-lane write commit and read-drive decisions.
    for (genvar l = 0; l < LANES; l++) begin : g_lane_dec
        always_comb begin
            lane_we[l]  = !ce_q && !wr_q[l] && (wr_n[l] || ce_n);
            lane_drv[l] = !ce_n && !oe_n[l] && wr_n[l];
        end
    end

    // Refresh triggers: quiet chip-enable access end, or request edge while idle.
    always_comb begin
        ce_ref_go = ce_rise && !touched;
        auto_go   = ce_n && ce_q && rf_q && !oe_n[LANE_LO];
    end

    // Sample history, address latch and access-activity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q     <= 1'b1;
            wr_q     <= '1;
            rf_q     <= 1'b1;
            addr_lat <= '0;
            touched  <= 1'b0;
        end else begin
            ce_q <= ce_n;
            wr_q <= wr_n;
            rf_q <= oe_n[LANE_LO];
            if (ce_fall) begin
                addr_lat <= addr;
            end
            if (!ce_n) begin
                touched <= (ce_fall ? 1'b0 : touched) | busy_now;
            end
        end
    end
endmodule

// File: rtl/psram_lane.sv
// psram_lane: storage and read register for one byte lane.
// Assumes a write and a read of the same word at one sample return the new
// byte; the read register only loads when the lane is to be driven.
module psram_lane #(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                drv_nxt,
    output logic [BYTE_W-1:0]   rdata,
    output logic                drv
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    // Array write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_addr] <= wdata;
        end
    end

    // Read register with same-sample write bypass, plus drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv   <= 1'b0;
            rdata <= '0;
        end else begin
            drv <= drv_nxt;
            if (drv_nxt) begin
                rdata <= (we && (rd_addr == wr_addr)) ? wdata : mem[rd_addr];
            end
        end
    end
endmodule

// File: rtl/psram_refresh.sv
// psram_refresh: internal row counter and the refresh report to the row
// decoder. Assumes the two triggers never fire at the same sample.
module psram_refresh #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_ref_go,
    input  logic [ROW_W-1:0] ce_row,
    input  logic             auto_go,
    output logic             ref_valid,
    output logic [ROW_W-1:0] ref_row,
    output logic [ROW_W-1:0] row_cnt
);
    // Refresh report and wrapping row counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_valid <= 1'b0;
            ref_row   <= '0;
            row_cnt   <= '0;
        end else if (auto_go) begin
            ref_valid <= 1'b1;
            ref_row   <= row_cnt;
            row_cnt   <= row_cnt + 1'b1;
        end else if (ce_ref_go) begin
            ref_valid <= 1'b1;
            ref_row   <= ce_row;
        end else begin
            ref_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/psram_core.sv
// psram_core: top of the pseudo-static RAM model. Joins the control decoder,
// the two byte lanes and the refresh logic. Assumes a byte width of 8 and
// a row field in the low ROW_W address bits.
module psram_core #(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 8,
    parameter int ROW_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_lo_n,
    input  logic                  wr_hi_n,
    input  logic                  oe_lo_rf_n,
    input  logic                  oe_hi_n,
    input  logic [2*BYTE_W-1:0]   din,
    output logic [2*BYTE_W-1:0]   dout,
    output logic                  drv_lo,
    output logic                  drv_hi,
    output logic                  ref_valid,
    output logic [ROW_W-1:0]      ref_row
);
    import psram_pkg::*;

    logic [LANES-1:0]   wr_n;
    logic [LANES-1:0]   oe_n;
    logic [ADDR_W-1:0]  rd_addr;
    logic [ADDR_W-1:0]  wr_addr;
    logic [LANES-1:0]   lane_we;
    logic [LANES-1:0]   lane_drv;
    logic [LANES-1:0]   drv;
    logic               ce_ref_go;
    logic               auto_go;
    logic [ROW_W-1:0]   ce_row;
    logic [ROW_W-1:0]   row_cnt;

    // Gather per-lane pins into vectors.
    always_comb begin
        wr_n   = {wr_hi_n, wr_lo_n};
        oe_n   = {oe_hi_n, oe_lo_rf_n};
        drv_lo = drv[LANE_LO];
        drv_hi = drv[LANE_HI];
    end

    psram_ctrl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .addr      (addr),
        .wr_n      (wr_n),
        .oe_n      (oe_n),
        .rd_addr   (rd_addr),
        .wr_addr   (wr_addr),
        .lane_we   (lane_we),
        .lane_drv  (lane_drv),
        .ce_ref_go (ce_ref_go),
        .ce_row    (ce_row),
        .auto_go   (auto_go)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        psram_lane #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (lane_we[l]),
            .wr_addr (wr_addr),
            .wdata   (din[l*BYTE_W +: BYTE_W]),
            .rd_addr (rd_addr),
            .drv_nxt (lane_drv[l]),
            .rdata   (dout[l*BYTE_W +: BYTE_W]),
            .drv     (drv[l])
        );
    end

    psram_refresh #(.ROW_W(ROW_W)) u_refresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_ref_go (ce_ref_go),
        .ce_row    (ce_row),
        .auto_go   (auto_go),
        .ref_valid (ref_valid),
        .ref_row   (ref_row),
        .row_cnt   (row_cnt)
    );
endmodule

// File: rtl/psram_core_chk.sv
// psram_core_chk: protocol properties of psram_core, bound to every instance.
module psram_core_chk #(
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             wr_lo_n,
    input logic             wr_hi_n,
    input logic             oe_lo_rf_n,
    input logic             oe_hi_n,
    input logic             drv_lo,
    input logic             drv_hi,
    input logic             ref_valid,
    input logic             auto_go,
    input logic [ROW_W-1:0] row_cnt
);
    assert_idle_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!drv_lo && !drv_hi));

    assert_write_wins_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo_n |=> !drv_lo);

    assert_write_wins_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi_n |=> !drv_hi);

    assert_drive_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hi |-> $past(!ce_n && !oe_hi_n && wr_hi_n));

    assert_refresh_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> (!drv_lo && !drv_hi));

    assert_counter_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        auto_go |=> (row_cnt == $past(row_cnt) + 1'b1) && ref_valid);
endmodule

bind psram_core psram_core_chk #(.ROW_W(ROW_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .wr_lo_n    (wr_lo_n),
    .wr_hi_n    (wr_hi_n),
    .oe_lo_rf_n (oe_lo_rf_n),
    .oe_hi_n    (oe_hi_n),
    .drv_lo     (drv_lo),
    .drv_hi     (drv_hi),
    .ref_valid  (ref_valid),
    .auto_go    (auto_go),
    .row_cnt    (row_cnt)
);

// File: tb/test_psram_core.sv
// Bench for psram_core: a behavioural reference model updated per sample
// and compared against every output on every clock.
module test_psram_core;
    localparam int AW = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic        wr_lo_n = 1'b1, wr_hi_n = 1'b1, oe_lo_rf_n = 1'b1, oe_hi_n = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        drv_lo, drv_hi, ref_valid;
    logic [7:0]  ref_row;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    // reference model state
    logic [15:0] m_mem [int];
    bit       m_ce_q = 1, m_rf_q = 1, m_touch = 0;
    bit [1:0] m_wr_q = 2'b11;
    int       m_lat = 0;
    int       m_cnt = 0;
    bit [1:0] e_drv;
    logic [15:0] e_dout;
    bit       e_ref;
    int       e_row;

    psram_core i_psram_core (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr(addr),
        .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .oe_lo_rf_n(oe_lo_rf_n),
        .oe_hi_n(oe_hi_n), .din(din), .dout(dout), .drv_lo(drv_lo),
        .drv_hi(drv_hi), .ref_valid(ref_valid), .ref_row(ref_row)
    );

    always #2 clk = ~clk;

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired (%s) actual=hung expected=done", cur_req);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Advance the reference model by one sample of the current pins.
    task automatic model_step();
        bit fall, rise;
        int rd;
        bit [1:0] wr, oe;
        logic [15:0] w;
        wr = {wr_hi_n, wr_lo_n};
        oe = {oe_hi_n, oe_lo_rf_n};
        fall = !ce_n && m_ce_q;
        rise = ce_n && !m_ce_q;
        for (int l = 0; l < 2; l++) begin
            if (!m_ce_q && !m_wr_q[l] && (wr[l] || ce_n)) begin
                w = m_mem.exists(m_lat) ? m_mem[m_lat] : 16'h0;
                w[l*8 +: 8] = din[l*8 +: 8];
                m_mem[m_lat] = w;
            end
        end
        rd = fall ? int'(addr) : m_lat;
        e_dout = m_mem.exists(rd) ? m_mem[rd] : 16'h0;
        for (int l = 0; l < 2; l++) e_drv[l] = !ce_n && !oe[l] && wr[l];
        e_ref = 0;
        if (ce_n && m_ce_q && m_rf_q && !oe_lo_rf_n) begin
            e_ref = 1; e_row = m_cnt; m_cnt = (m_cnt + 1) % 256;
        end else if (rise && !m_touch) begin
            e_ref = 1; e_row = m_lat % 256;
        end
        if (!ce_n) m_touch = (fall ? 1'b0 : m_touch) | !(&{oe, wr});
        if (fall) m_lat = int'(addr);
        m_ce_q = ce_n; m_wr_q = wr; m_rf_q = oe_lo_rf_n;
    endtask

    // One clock: apply pins, predict, then compare after the edge.
    task automatic cyc(input bit ce, input int a, input bit wl, input bit wh,
                       input bit ol, input bit oh, input logic [15:0] d);
        ce_n = ce; addr = AW'(a); wr_lo_n = wl; wr_hi_n = wh;
        oe_lo_rf_n = ol; oe_hi_n = oh; din = d;
        model_step();
        @(posedge clk); #1;
        chk("drv_lo", int'(drv_lo), int'(e_drv[0]));
        chk("drv_hi", int'(drv_hi), int'(e_drv[1]));
        chk("ref_valid", int'(ref_valid), int'(e_ref));
        if (e_ref) chk("ref_row", int'(ref_row), e_row);
        if (e_drv[0] && drv_lo) chk("dout_lo", int'(dout[7:0]), int'(e_dout[7:0]));
        if (e_drv[1] && drv_hi) chk("dout_hi", int'(dout[15:8]), int'(e_dout[15:8]));
    endtask

    // Write access committed by strobe release; 'mv' is where addr wanders to.
    task automatic wr_strobe(input int a, input int mv, input bit lo, input bit hi,
                             input logic [15:0] d);
        cyc(0, a, 1, 1, 1, 1, 16'hdead);
        cyc(0, mv, !lo, !hi, 1, 1, 16'hbeef);
        cyc(0, mv, 1, 1, 1, 1, d);
        cyc(1, mv, 1, 1, 1, 1, 16'h0);
    endtask

    // Read access with per-lane output enables.
    task automatic rd_word(input int a, input int mv, input bit lo, input bit hi);
        cyc(0, a, 1, 1, !lo, !hi, 16'h0);
        cyc(0, mv, 1, 1, !lo, !hi, 16'h0);
        cyc(1, mv, 1, 1, 1, 1, 16'h0);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1;
        chk("drv_lo in reset", int'(drv_lo), 0);
        chk("ref_valid in reset", int'(ref_valid), 0);
        rst_n = 1'b1;
        cyc(1, 0, 1, 1, 1, 1, 0);
        cyc(1, 0, 1, 1, 0, 1, 0);   // first auto refresh reports row 0
        cyc(1, 0, 1, 1, 1, 1, 0);

        // R3: strobe-release writes, each lane alone and both
        cur_req = "R3";
        wr_strobe(16'h012, 16'h012, 1, 1, 16'h1234);
        wr_strobe(16'h012, 16'h012, 1, 0, 16'hffaa);
        wr_strobe(16'h012, 16'h012, 0, 1, 16'h55ff);
        rd_word(16'h012, 16'h012, 1, 1);
        wr_strobe(16'h7c3, 16'h7c3, 1, 1, 16'hc0de);

        // R2: address pins wander after the latch edge
        cur_req = "R2";
        wr_strobe(16'h100, 16'h200, 1, 1, 16'habcd);
        rd_word(16'h200, 16'h100, 1, 1);
        rd_word(16'h100, 16'h7c3, 1, 1);

        // R4: commit by chip-enable release with strobes still low
        cur_req = "R4";
        cyc(0, 16'h055, 1, 1, 1, 1, 0);
        cyc(0, 16'h055, 0, 0, 1, 1, 16'h1111);
        cyc(1, 16'h055, 0, 0, 1, 1, 16'h9876);
        cyc(1, 16'h055, 1, 1, 1, 1, 16'h0);
        rd_word(16'h055, 16'h055, 1, 1);

        // R5: reads with single-lane enables and read after write in one access
        cur_req = "R5";
        rd_word(16'h012, 16'h000, 1, 0);
        rd_word(16'h012, 16'h000, 0, 1);
        cyc(0, 16'h066, 1, 1, 1, 1, 0);
        cyc(0, 16'h066, 0, 1, 1, 1, 16'h00a5);
        cyc(0, 16'h066, 1, 1, 0, 1, 16'h005a);
        cyc(1, 16'h066, 1, 1, 1, 1, 0);

        // R6: strobe and output enable low together on one lane
        cur_req = "R6";
        cyc(0, 16'h077, 1, 1, 0, 0, 0);
        cyc(0, 16'h077, 0, 1, 0, 0, 16'h3c3c);
        cyc(0, 16'h077, 1, 0, 0, 0, 16'h4242);
        cyc(0, 16'h077, 1, 1, 0, 0, 16'h0);
        cyc(1, 16'h077, 1, 1, 1, 1, 0);

        // R7: standby with other pins toggling
        cur_req = "R7";
        for (int i = 0; i < 8; i++)
            cyc(1, i * 37, i[0], i[1], 1, i[2], 16'(i * 16'h1357));

        // R8: chip-enable-only refresh of several rows
        cur_req = "R8";
        for (int i = 0; i < 4; i++) begin
            cyc(0, 16'h300 + i * 61, 1, 1, 1, 1, 0);
            cyc(0, 16'h0ff, 1, 1, 1, 1, 0);
            cyc(1, 16'h0ff, 1, 1, 1, 1, 0);
        end

        // R9: auto refresh across the counter wrap, junk on ignored pins
        cur_req = "R9";
        for (int i = 0; i < 260; i++) begin
            cyc(1, i * 13, i[0], i[1], 0, i[2], 16'(i));
            cyc(1, i * 7, i[1], i[0], 1, i[3], 16'(~i));
        end
        rd_word(16'h012, 16'h012, 1, 1);
        rd_word(16'h100, 16'h100, 1, 1);
        rd_word(16'h055, 16'h055, 1, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule